// File: doc/BRIEF.md
# Power Rail Removal Controller

This block tells the platform when a serial-link controller is idle enough for one of its supply rails to be switched off, and it sequences the link's safe return once power comes back. Five link conditions can each request removal: link disabled, L23 entered for runtime D3, no device detected while the link is unowned, clock request released while in Detect, and function disabled. Each condition has its own software enable bit. The active-low removal-enable output goes low while any enabled condition holds. It goes high again when none holds, or when the power controller signals restore.

On the return path, a restore from the power controller puts the block into its exit sequence. Link reset is asserted and the boundary lock is held. Link reset stays asserted until restore has dropped, the link PLL is locked, and a programmable suppression delay has run out. The boundary lock is released by a second programmable delay. That delay runs only after link reset has been released, context propagation has finished and the early boundary lock has dropped. Both delays, along with the enable bits, sit in one 32-bit configuration word.

Top module: `rail_release_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0x00000020: all enables 0, suppression latency 1 and propagation latency 0. After reset, `rail_rm_en_n` is 1 and `link_rst` and `bnd_lock` are 0.
- R2: Writing the word updates and reads back bits 8:0. The layout is: [0] link-disabled enable, [1] L23/D3 enable, [2] no-device enable, [3] hot-plug enable, [4] function-disabled enable, [6:5] suppression latency, [8:7] propagation latency. Bits 31:9 always read 0.
- R3: With bit 0 set and `lk_disabled` high (and no restore), `rail_rm_en_n` is 0 one cycle later.
- R4: With bit 1 set and `lk_l23_d3` high, `rail_rm_en_n` is 0 one cycle later.
- R5: With bit 2 set, `rail_rm_en_n` is 0 one cycle later only when both `lk_no_dev` and `lk_unowned` are high.
- R6: With bit 3 set, `rail_rm_en_n` is 0 one cycle later only when `lk_in_detect` is high and `clkreq_n` is high (clock request released).
- R7: With bit 4 set and `lk_fn_off` high, `rail_rm_en_n` is 0 one cycle later.
- R8: A condition whose enable bit is clear has no effect. `rail_rm_en_n` returns to 1 one cycle after no enabled condition holds.
- R9: While `pm_restore` is high, `rail_rm_en_n` is 1 one cycle later, whatever the conditions.
- R10: `pm_restore` high sets `link_rst` and `bnd_lock` to 1 on the next edge. `link_rst` stays 1 while `pm_restore` is high or `pll_locked` is low, and it never rises without a restore.
- R11: Once `pm_restore` is low and `pll_locked` is high, `link_rst` falls after (S+1)×16 such cycles, where S is the suppression latency.
- R12: `bnd_lock` falls after (P+1)×16 cycles in which `link_rst` is 0, `ctx_done` is 1 and `early_bl` is 0, where P is the propagation latency. It never falls while any of these is not met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| lk_disabled | input | 1 | Link is in the disabled state |
| lk_l23_d3 | input | 1 | Link entered L23 for runtime D3 |
| lk_no_dev | input | 1 | Detect found no device |
| lk_unowned | input | 1 | Link has no owner |
| lk_in_detect | input | 1 | Link state machine is in Detect |
| clkreq_n | input | 1 | Active-low clock request from the device |
| lk_fn_off | input | 1 | Function is disabled |
| pm_restore | input | 1 | Restore indication from the power controller |
| pll_locked | input | 1 | Link PLL lock |
| ctx_done | input | 1 | Context propagation finished |
| early_bl | input | 1 | Early boundary lock still asserted |
| rail_rm_en_n | output | 1 | Active-low rail removal enable |
| link_rst | output | 1 | Link reset held during exit |
| bnd_lock | output | 1 | Boundary lock held during exit |

## Verification
Each removal condition is driven on its own with only its enable set, and a near miss is driven next to it: no device while owned, Detect with clock request still asserted, clock request released outside Detect. These pairs show that the gating terms are combined correctly and not just ORed in. A random phase writes arbitrary enable masks against arbitrary condition and restore patterns. It catches a mis-mapped enable bit or a restore that fails to override. The exit sequence runs with several latency codes, with the PLL lock held back, and with the context-done and early-lock gates held back. These runs tell apart the length of each delay, its start point, and the order of the two delays.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

   // number of removal conditions and width of each latency code
   localparam int NCOND = 5;
   localparam int LAT_W = 2;

   // condition slots; also the enable bit positions in the config word
   localparam int C_LDIS  = 0;
   localparam int C_L23   = 1;
   localparam int C_NODEV = 2;
   localparam int C_HPLUG = 3;
   localparam int C_FNOFF = 4;

   localparam int CFG_BITS = NCOND + 2 * LAT_W;

   typedef struct packed {
      logic [LAT_W-1:0] prop_lat;
      logic [LAT_W-1:0] sup_lat;
      logic [NCOND-1:0] en;
   } rrc_cfg_t;

endpackage

// File: rtl/rrc_regs.sv
module rrc_regs
   import rrc_pkg::*;
#(
   parameter int SUP_RST  = 1,
   parameter int PROP_RST = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [31:0] wdata,
   output rrc_cfg_t    cfg,
   output logic [31:0] rdata
);

   localparam int PAD_W = 32 - CFG_BITS;

   logic unused_hi;
   assign unused_hi = ^wdata[31:CFG_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.en       <= '0;
         cfg.sup_lat  <= LAT_W'(SUP_RST);
         cfg.prop_lat <= LAT_W'(PROP_RST);
      end else if (we) begin
         cfg <= rrc_cfg_t'(wdata[CFG_BITS-1:0]);
      end
   end

   assign rdata = {{PAD_W{1'b0}}, cfg};

endmodule

// File: rtl/rrc_cond.sv
module rrc_cond #(
   parameter int NC      = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] en,
   input  logic [NC-1:0] raw,
   input  logic          restore,
   output logic          rm_n
);

   logic [NC-1:0] hit;
   logic          want;

   for (genvar i = 0; i < NC; i++) begin : g_gate
      assign hit[i] = en[i] & raw[i];
   end

   assign want = (|hit) & ~restore;

   if (REG_OUT) begin : g_reg
      logic rm_n_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rm_n_q <= 1'b1;
         else        rm_n_q <= ~want;
      end
      assign rm_n = rm_n_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rm_n = ~want;
   end

endmodule

// File: rtl/rrc_delay.sv
module rrc_delay #(
   parameter int LAT_W    = 2,
   parameter int LAT_UNIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             run,
   input  logic [LAT_W-1:0] lat,
   output logic             busy
);

   localparam int MAXC  = (1 << LAT_W) * LAT_UNIT;
   localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = CNT_W'((int'(lat) + 1) * LAT_UNIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (arm) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy && run) begin
         if (cnt == last) busy <= 1'b0;
         else             cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rail_release_ctrl.sv
module rail_release_ctrl
   import rrc_pkg::*;
#(
   parameter int LAT_UNIT = 16,
   parameter int SUP_RST  = 1,
   parameter int PROP_RST = 0,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        lk_disabled,
   input  logic        lk_l23_d3,
   input  logic        lk_no_dev,
   input  logic        lk_unowned,
   input  logic        lk_in_detect,
   input  logic        clkreq_n,
   input  logic        lk_fn_off,
   input  logic        pm_restore,
   input  logic        pll_locked,
   input  logic        ctx_done,
   input  logic        early_bl,
   output logic        rail_rm_en_n,
   output logic        link_rst,
   output logic        bnd_lock
);

   initial begin
      assert (LAT_UNIT >= 1) else $error("LAT_UNIT must be at least 1");
      assert (SUP_RST >= 0 && SUP_RST < (1 << LAT_W)) else $error("SUP_RST out of range");
      assert (PROP_RST >= 0 && PROP_RST < (1 << LAT_W)) else $error("PROP_RST out of range");
   end

   rrc_cfg_t         cfg;
   logic [NCOND-1:0] raw;
   logic             sup_run;
   logic             prop_run;

   rrc_regs #(
      .SUP_RST (SUP_RST),
      .PROP_RST(PROP_RST)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cfg_we),
      .wdata(cfg_wdata),
      .cfg  (cfg),
      .rdata(cfg_rdata)
   );

   assign raw[C_LDIS]  = lk_disabled;
   assign raw[C_L23]   = lk_l23_d3;
   assign raw[C_NODEV] = lk_no_dev & lk_unowned;
   assign raw[C_HPLUG] = lk_in_detect & clkreq_n;
   assign raw[C_FNOFF] = lk_fn_off;

   rrc_cond #(
      .NC     (NCOND),
      .REG_OUT(REG_OUT)
   ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg.en),
      .raw    (raw),
      .restore(pm_restore),
      .rm_n   (rail_rm_en_n)
   );

   // suppression delay counts once restore is gone and the PLL is locked
   assign sup_run = ~pm_restore & pll_locked;

   rrc_delay #(
      .LAT_W   (LAT_W),
      .LAT_UNIT(LAT_UNIT)
   ) u_sup (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (pm_restore),
      .run  (sup_run),
      .lat  (cfg.sup_lat),
      .busy (link_rst)
   );

   // propagation delay is chained behind the release of link reset
   assign prop_run = ~link_rst & ctx_done & ~early_bl;

   rrc_delay #(
      .LAT_W   (LAT_W),
      .LAT_UNIT(LAT_UNIT)
   ) u_prop (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (pm_restore),
      .run  (prop_run),
      .lat  (cfg.prop_lat),
      .busy (bnd_lock)
   );

endmodule

// File: rtl/rrc_checker.sv
module rrc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cfg_rdata,
   input logic        lk_disabled,
   input logic        lk_fn_off,
   input logic        pm_restore,
   input logic        pll_locked,
   input logic        ctx_done,
   input logic        link_rst,
   input logic        bnd_lock,
   input logic        rail_rm_en_n
);

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[31:9] == 23'd0);

   p_ldis_removes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && lk_disabled && !pm_restore) |=> !rail_rm_en_n);

   p_fnoff_removes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[4] && lk_fn_off && !pm_restore) |=> !rail_rm_en_n);

   p_no_enable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[4:0] == 5'd0) |=> rail_rm_en_n);

   p_restore_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pm_restore |=> rail_rm_en_n);

   p_restore_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pm_restore |=> (link_rst && bnd_lock));

   p_unlocked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (link_rst && !pll_locked) |=> link_rst);

   p_rst_needs_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_rst) |-> $past(pm_restore));

   p_lock_after_rst_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_lock && link_rst) |=> bnd_lock);

   p_lock_waits_ctx_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_lock && !ctx_done) |=> bnd_lock);

endmodule

bind rail_release_ctrl rrc_checker i_rrc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_rdata   (cfg_rdata),
   .lk_disabled (lk_disabled),
   .lk_fn_off   (lk_fn_off),
   .pm_restore  (pm_restore),
   .pll_locked  (pll_locked),
   .ctx_done    (ctx_done),
   .link_rst    (link_rst),
   .bnd_lock    (bnd_lock),
   .rail_rm_en_n(rail_rm_en_n)
);

// File: tb/test_rail_release_ctrl.sv
`timescale 1ns/1ps
module test_rail_release_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_disabled = 1'b0, lk_l23_d3 = 1'b0, lk_no_dev = 1'b0;
   logic        lk_unowned = 1'b0, lk_in_detect = 1'b0, clkreq_n = 1'b0;
   logic        lk_fn_off = 1'b0;
   logic        pm_restore = 1'b0, pll_locked = 1'b1;
   logic        ctx_done = 1'b1, early_bl = 1'b0;
   logic        rail_rm_en_n, link_rst, bnd_lock;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   rail_release_ctrl i_rail_release_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .lk_disabled(lk_disabled), .lk_l23_d3(lk_l23_d3),
      .lk_no_dev(lk_no_dev), .lk_unowned(lk_unowned), .lk_in_detect(lk_in_detect),
      .clkreq_n(clkreq_n), .lk_fn_off(lk_fn_off), .pm_restore(pm_restore),
      .pll_locked(pll_locked), .ctx_done(ctx_done), .early_bl(early_bl),
      .rail_rm_en_n(rail_rm_en_n), .link_rst(link_rst), .bnd_lock(bnd_lock)
   );

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_cfg(logic [4:0] en, logic [1:0] sup, logic [1:0] prop);
      return {23'd0, prop, sup, en};
   endfunction

   // pins = {ldis, l23, nodev, unowned, detect, clkreq_n, fnoff}
   function automatic bit exp_rm_n(logic [4:0] en, logic [6:0] p, bit rst);
      logic [4:0] c;
      c[0] = p[6];
      c[1] = p[5];
      c[2] = p[4] & p[3];
      c[3] = p[2] & p[1];
      c[4] = p[0];
      return !((|(c & en)) && !rst);
   endfunction

   task automatic wr(logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_pins(logic [6:0] p);
      {lk_disabled, lk_l23_d3, lk_no_dev, lk_unowned, lk_in_detect, clkreq_n, lk_fn_off} = p;
   endtask

   task automatic try_cond(string req, logic [4:0] en, logic [6:0] p);
      wr(mk_cfg(en, 2'd1, 2'd0));
      set_pins(p);
      @(negedge clk);
      chk(rail_rm_en_n == exp_rm_n(en, p, 1'b0), req, "rail_rm_en_n",
          rail_rm_en_n, exp_rm_n(en, p, 1'b0));
      set_pins(7'd0);
      @(negedge clk);
   endtask

   // gate: 0 none, 1 ctx_done held low, 2 early_bl held high
   task automatic exit_seq(logic [1:0] sup, logic [1:0] prop, int lock_wait, int gate);
      int n, m, c;
      n = (int'(sup) + 1) * 16;
      m = (int'(prop) + 1) * 16;
      wr(mk_cfg(5'd0, sup, prop));
      pll_locked = 1'b0;
      ctx_done = (gate != 1);
      early_bl = (gate == 2);
      pm_restore = 1'b1;
      @(negedge clk);
      chk(link_rst == 1'b1, "R10", "link_rst after restore", link_rst, 1);
      chk(bnd_lock == 1'b1, "R10", "bnd_lock after restore", bnd_lock, 1);
      pm_restore = 1'b0;
      repeat (lock_wait) @(negedge clk);
      chk(link_rst == 1'b1, "R10", "link_rst while unlocked", link_rst, 1);
      pll_locked = 1'b1;
      c = 0;
      do begin @(negedge clk); c++; end while (link_rst && c < 2000);
      chk(c == n, "R11", "suppression length", c, n);
      if (gate == 0) begin
         while (bnd_lock && c < 4000) begin @(negedge clk); c++; end
         chk(c == n + m, "R12", "boundary release time", c, n + m);
      end else begin
         repeat (12) @(negedge clk);
         chk(bnd_lock == 1'b1, "R12", "bnd_lock while gated", bnd_lock, 1);
         ctx_done = 1'b1;
         early_bl = 1'b0;
         c = 0;
         do begin @(negedge clk); c++; end while (bnd_lock && c < 2000);
         chk(c == m, "R12", "propagation length", c, m);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(cfg_rdata == 32'h20, "R1", "cfg reset", cfg_rdata, 32'h20);
      chk(rail_rm_en_n == 1'b1, "R1", "rail_rm_en_n reset", rail_rm_en_n, 1);
      chk(link_rst == 1'b0, "R1", "link_rst reset", link_rst, 0);
      chk(bnd_lock == 1'b0, "R1", "bnd_lock reset", bnd_lock, 0);

      // R2 layout and reserved bits
      wr(32'hFFFF_FFFF);
      chk(cfg_rdata == 32'h1FF, "R2", "all-ones write", cfg_rdata, 32'h1FF);
      wr(32'h5555_5155);
      chk(cfg_rdata == 32'h155, "R2", "pattern write", cfg_rdata, 32'h155);

      // single conditions and near misses
      try_cond("R3", 5'b00001, 7'b1000000);
      try_cond("R4", 5'b00010, 7'b0100000);
      try_cond("R5", 5'b00100, 7'b0011000);
      try_cond("R5", 5'b00100, 7'b0010000);
      try_cond("R6", 5'b01000, 7'b0000110);
      try_cond("R6", 5'b01000, 7'b0000100);
      try_cond("R6", 5'b01000, 7'b0000010);
      try_cond("R7", 5'b10000, 7'b0000001);
      try_cond("R8", 5'b11110, 7'b1000000);
      try_cond("R8", 5'b11111, 7'b0000000);

      // R8 release when condition drops
      wr(mk_cfg(5'b00001, 2'd1, 2'd0));
      lk_disabled = 1'b1;
      @(negedge clk);
      chk(rail_rm_en_n == 1'b0, "R8", "asserted before drop", rail_rm_en_n, 0);
      lk_disabled = 1'b0;
      @(negedge clk);
      chk(rail_rm_en_n == 1'b1, "R8", "released after drop", rail_rm_en_n, 1);

      // R9 restore overrides an active condition
      lk_disabled = 1'b1;
      @(negedge clk);
      pm_restore = 1'b1;
      @(negedge clk);
      chk(rail_rm_en_n == 1'b1, "R9", "restore overrides", rail_rm_en_n, 1);
      pm_restore = 1'b0;
      lk_disabled = 1'b0;
      repeat (200) @(negedge clk);

      // exit sequences
      exit_seq(2'd1, 2'd0, 0, 0);
      exit_seq(2'd0, 2'd3, 5, 0);
      exit_seq(2'd3, 2'd1, 3, 1);
      exit_seq(2'd2, 2'd2, 0, 2);

      // random mix for the removal decision
      for (int i = 0; i < 300; i++) begin
         logic [4:0] en;
         logic [6:0] p;
         bit         r;
         en = 5'($urandom);
         p  = 7'($urandom);
         r  = (($urandom % 8) == 0);
         wr(mk_cfg(en, 2'd0, 2'd0));
         set_pins(p);
         pm_restore = r;
         @(negedge clk);
         chk(rail_rm_en_n == exp_rm_n(en, p, r), "R8", "random mix",
             rail_rm_en_n, exp_rm_n(en, p, r));
         pm_restore = 1'b0;
      end
      set_pins(7'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule